// File: doc/BRIEF.md
# Watchdog-capable general-purpose timer channel

One 16-bit up-counting timer channel behind a small word-addressed register bus. A programmable power-of-two prescaler paces the counter, and its source is either every clock or a tick strobe from outside. Two comparators watch the counter. Each has its own 2-bit match mode and its own sticky status flag. The channel can therefore serve as a periodic timer, a one-shot event marker or, once reset requests are enabled, a system watchdog.

To arm the channel as a watchdog, software writes the setup word once, clears the counter, loads the timeout into compare 2 and then sets the count-enable bit. If compare 2 is reached while the external reset-enable input is high, the block raises a reset request for one cycle.

The setup word is guarded by a two-state machine. CFG_OPEN is the state after reset. The first write to the setup register moves it to CFG_LOCKED, and only a reset brings it back to CFG_OPEN. In CFG_OPEN, a setup write loads the configuration fields. In CFG_LOCKED, only the run bit and the status flags respond to writes.

Top module: `gpt_wdt_timer`

## Requirements
- R1: After reset, all four registers read 0 (including the lock bit, setup bit 12) and `wd_rst_req` is low.
- R2: Register words are selected by `bus_addr[2:1]`: 0 = compare 1, 1 = compare 2, 2 = counter, 3 = setup. A request with `bus_addr[0]` = 1 is ignored. Read data appears on `bus_rdata` in the cycle after the read request, and compare and counter registers read back what was written.
- R3: With the run bit (setup bit 15) set and divider field n (setup bits 3:0), the counter advances once every 2^n source ticks. With the run bit clear, the counter holds its value.
- R4: Setup bit 4 chooses the source tick: 0 = every clock cycle, 1 = only cycles in which `ext_tick` is high.
- R5: The first setup write loads setup bits 11:0 (bit 10 always reads 0) and sets the lock, so bit 12 reads 1. Later setup writes leave bits 11:0 unchanged until reset.
- R6: Compare 1 mode is in setup bits 7:6 and compare 2 mode in bits 9:8, with the encodings 0 = off, 1 = equality, 2 = counter greater than or equal to compare value, 3 = event (equality, no restart). A comparison is made only on an advance step, against the counter value before that step.
- R7: A hit on compare 1 or 2 sets setup bit 13 or 14 respectively. The flag stays set until software writes 1 to it, and writing 0 leaves it unchanged. The run bit stays writable after the lock.
- R8: A compare-2 hit in mode 1 or 2 loads the counter with 0 instead of incrementing it. In mode 3 the counter keeps incrementing.
- R9: `wd_rst_req` is high for exactly the cycle after a compare-2 hit that occurs while `wd_rst_en` is high, and it is low at all other times.
- R10: A counter write loads the written value and restarts the prescaler phase, so the next advance comes a full 2^n source ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_tick | input | 1 | Alternative count source strobe |
| wd_rst_en | input | 1 | Allows compare 2 to request a system reset |
| wd_rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong prescaler phase or divider decode shows up as a wrong counter value on the next read. The same read after any timed run of a known number of clocks exposes it. A stuck or early lock changes the setup readback at once, on the read that follows the second setup write. A wrong comparator decode shows up differently depending on where it goes wrong. It can set a flag that should stay clear, it can restart the counter in event mode, or it can produce a reset pulse when none is expected. Each of these becomes visible on the first read or pulse count after the advance step that should, or should not, have matched.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int REG_W      = 16;
    localparam int CFG_W      = 12;
    localparam int N_CMP      = 2;
    localparam int BIT_CLKSEL = 4;
    localparam int BIT_FLAG0  = 13;
    localparam int BIT_RUN    = 15;
    localparam logic [CFG_W-1:0] CFG_MASK = 12'hBFF;

    typedef enum logic [1:0] {
        CMP_OFF = 2'd0,
        CMP_EQ  = 2'd1,
        CMP_GE  = 2'd2,
        CMP_EVT = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

    typedef enum logic [1:0] {
        REG_CMP1  = 2'd0,
        REG_CMP2  = 2'd1,
        REG_COUNT = 2'd2,
        REG_SETUP = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_tick,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        limit    = PRE_W'((32'd1 << div) - 32'd1);
        at_limit = (phase_q == limit);
        step     = run & src_tick & at_limit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || !run) begin
            phase_q <= '0;
        end else if (src_tick) begin
            phase_q <= at_limit ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpt_compare.sv
module gpt_compare
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      step,
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    input  cmp_mode_e mode,
    output logic      hit
);
    logic match;

    always_comb begin
        unique case (mode)
            CMP_OFF:         match = 1'b0;
            CMP_EQ, CMP_EVT: match = (count == limit);
            CMP_GE:          match = (count >= limit);
        endcase
        hit = step & match;
    end
endmodule

// File: rtl/gpt_setup_ctl.sv
module gpt_setup_ctl
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_setup,
    input  logic [W-1:0]     wdata,
    input  logic [N_CMP-1:0] hit,
    output logic [CFG_W-1:0] cfg,
    output logic             run,
    output logic [N_CMP-1:0] flags,
    output logic             locked
);
    cfg_state_e state_q, state_d;
    logic       cfg_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (wr_setup) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        locked   = (state_q == CFG_LOCKED);
        cfg_load = wr_setup && (state_q == CFG_OPEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            run <= 1'b0;
        end else begin
            if (cfg_load) cfg <= wdata[CFG_W-1:0] & CFG_MASK;
            if (wr_setup) run <= wdata[BIT_RUN];
        end
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= hit[g] |
                                    (flags[g] & ~(wr_setup & wdata[BIT_FLAG0+g]));
        end
    end
endmodule

// File: rtl/gpt_wdt_timer.sv
module gpt_wdt_timer
    import gpt_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int DIV_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    input  logic              wd_rst_en,
    output logic              wd_rst_req
);
    reg_sel_e          bus_sel;
    logic              acc, wr, rd;
    logic              wr_setup, cnt_wr;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] cmp_q [N_CMP];
    logic [N_CMP-1:0]  hit;
    logic [N_CMP-1:0]  flags;
    logic [CFG_W-1:0]  cfg;
    logic              run, locked, step, src_tick, restart;
    logic [DATA_W-1:0] rd_mux;
    cmp_mode_e         mode [N_CMP];

    always_comb begin
        acc      = bus_en & ~bus_addr[0];
        wr       = acc & bus_we;
        rd       = acc & ~bus_we;
        bus_sel  = reg_sel_e'(bus_addr[2:1]);
        wr_setup = wr && (bus_sel == REG_SETUP);
        cnt_wr   = wr && (bus_sel == REG_COUNT);
        src_tick = cfg[BIT_CLKSEL] ? ext_tick : 1'b1;
        mode[0]  = cmp_mode_e'(cfg[7:6]);
        mode[1]  = cmp_mode_e'(cfg[9:8]);
        restart  = hit[1] && (mode[1] == CMP_EQ || mode[1] == CMP_GE);
    end

    gpt_setup_ctl #(.W(DATA_W)) u_setup (
        .clk(clk), .rst_n(rst_n), .wr_setup(wr_setup), .wdata(bus_wdata),
        .hit(hit), .cfg(cfg), .run(run), .flags(flags), .locked(locked)
    );

    gpt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick),
        .clr(cnt_wr), .div(cfg[DIV_W-1:0]), .step(step)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)                                   cmp_q[g] <= '0;
            else if (wr && bus_sel == reg_sel_e'(g))      cmp_q[g] <= bus_wdata;
        end

        gpt_compare #(.W(DATA_W)) u_cmp (
            .step(step), .count(cnt), .limit(cmp_q[g]),
            .mode(mode[g]), .hit(hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (cnt_wr)  cnt <= bus_wdata;
        else if (step)    cnt <= restart ? '0 : cnt + 1'b1;
    end

    always_comb begin
        unique case (bus_sel)
            REG_CMP1:  rd_mux = cmp_q[0];
            REG_CMP2:  rd_mux = cmp_q[1];
            REG_COUNT: rd_mux = cnt;
            REG_SETUP: rd_mux = DATA_W'({run, flags[1], flags[0], locked, cfg});
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            wd_rst_req <= 1'b0;
        end else begin
            if (rd) bus_rdata <= rd_mux;
            wd_rst_req <= hit[1] & wd_rst_en;
        end
    end
endmodule

// File: rtl/gpt_wdt_checker.sv
module gpt_wdt_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              locked,
    input logic [11:0]       cfg,
    input logic [DATA_W-1:0] cnt,
    input logic              cnt_wr,
    input logic [1:0]        hit,
    input logic [1:0]        flags,
    input logic              wr_setup,
    input logic [DATA_W-1:0] wdata,
    input logic              wd_rst_en,
    input logic              wd_rst_req
);
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg)));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_hit_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != 2'b00) |-> run);

    p_flag1_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flags[0]);

    p_flag2_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_setup && wdata[14])) |=> flags[1]);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && (cfg[9:8] == 2'd1 || cfg[9:8] == 2'd2) && !cnt_wr) |=> (cnt == '0));

    p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> $past(hit[1] && wd_rst_en));

    p_rst_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && wd_rst_en) |=> wd_rst_req);
endmodule

bind gpt_wdt_timer gpt_wdt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .locked(locked), .cfg(cfg),
    .cnt(cnt), .cnt_wr(cnt_wr), .hit(hit), .flags(flags),
    .wr_setup(wr_setup), .wdata(bus_wdata), .wd_rst_en(wd_rst_en),
    .wd_rst_req(wd_rst_req)
);

// File: tb/gpt_wdt_timer_bench.sv
module gpt_wdt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_tick = 1'b0, wd_rst_en = 1'b0, wd_rst_req;

    int checks = 0, errors = 0, pulses = 0;
    bit done = 1'b0;
    bit rd_cap = 1'b0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    gpt_wdt_timer u_gpt_wdt_timer (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .wd_rst_en(wd_rst_en), .wd_rst_req(wd_rst_req)
    );

    // monitor: pops expected read data one cycle after each read request
    always @(posedge clk) rd_cap <= bus_en && !bus_we && !bus_addr[0];

    always @(negedge clk) begin
        if (rst_n && wd_rst_req) pulses++;
        if (rd_cap && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // runs the counter for exactly n enabled clock edges
    task automatic run_for(input int n);
        wr(3'd6, 16'h8000);
        idle(n - 1);
        wr(3'd6, 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(wd_rst_req, 0, "R1 reset request low");
        rd(3'd0, 16'h0000, "R1 compare1 reset");
        rd(3'd2, 16'h0000, "R1 compare2 reset");
        rd(3'd4, 16'h0000, "R1 counter reset");
        rd(3'd6, 16'h0000, "R1 setup reset, unlocked");

        // R5 lock: div 2, cmp1 equality, cmp2 greater-or-equal
        wr(3'd6, 16'h0242);
        rd(3'd6, 16'h1242, "R5 setup loaded and locked");
        wr(3'd6, 16'h0FFF);
        rd(3'd6, 16'h1242, "R5 config ignored after lock");

        // R2 register access
        wr(3'd0, 16'd3);
        wr(3'd2, 16'd100);
        wr(3'd4, 16'd0);
        wr(3'd1, 16'hBEEF);
        rd(3'd0, 16'd3, "R2 compare1 readback, odd address ignored");
        rd(3'd2, 16'd100, "R2 compare2 readback");

        // R3 divide by 4: 12 edges -> 3 advances, no equality at 0..2
        run_for(12);
        idle(4);
        rd(3'd4, 16'd3, "R3 prescaled count and hold");
        rd(3'd6, 16'h1242, "R6 no compare1 hit before value");

        // R6/R7 equality hit on counter value 3
        run_for(4);
        rd(3'd4, 16'd4, "R3 counter after one advance");
        rd(3'd6, 16'h3242, "R7 compare1 flag set");
        wr(3'd6, 16'h0000);
        rd(3'd6, 16'h3242, "R7 writing 0 keeps flag");
        wr(3'd6, 16'h2FFF);
        rd(3'd6, 16'h1242, "R7 write one clears flag");

        // R8/R9 compare2 ge restart with reset enabled
        wd_rst_en = 1'b1;
        wr(3'd2, 16'd5);
        run_for(4);
        rd(3'd4, 16'd5, "R8 below compare2");
        chk(pulses, 0, "R9 no pulse before hit");
        run_for(4);
        idle(1);
        rd(3'd4, 16'd0, "R8 counter restarted");
        rd(3'd6, 16'h5242, "R7 compare2 flag set");
        chk(pulses, 1, "R9 one reset pulse");

        // R9 no request while enable input low
        wd_rst_en = 1'b0;
        wr(3'd6, 16'h4000);
        wr(3'd4, 16'd4);
        run_for(4);
        run_for(4);
        idle(1);
        rd(3'd4, 16'd0, "R8 restart without reset enable");
        rd(3'd6, 16'h5242, "R7 flag set again");
        chk(pulses, 1, "R9 no pulse with enable low");

        // R10 counter write restarts prescaler phase
        wr(3'd6, 16'h8000);
        idle(1);
        wr(3'd4, 16'd10);
        idle(2);
        wr(3'd6, 16'h0000);
        rd(3'd4, 16'd10, "R10 prescaler phase restarted");

        // R6/R8 event mode: cmp1 ge, cmp2 event, divide by 1
        do_reset();
        wd_rst_en = 1'b1;
        wr(3'd6, 16'h0380);
        wr(3'd0, 16'd3);
        wr(3'd2, 16'd2);
        wr(3'd4, 16'd0);
        run_for(5);
        idle(1);
        rd(3'd4, 16'd5, "R8 event mode keeps counting");
        rd(3'd6, 16'h7380, "R6 ge and event flags");
        chk(pulses, 2, "R9 pulse on event hit");

        // R4 external tick source, comparators off
        do_reset();
        wr(3'd6, 16'h0010);
        wr(3'd4, 16'd0);
        wr(3'd6, 16'h8000);
        for (int i = 0; i < 7; i++) begin
            ext_tick = (i % 2 == 1);
            @(negedge clk);
        end
        ext_tick = 1'b0;
        wr(3'd6, 16'h0000);
        rd(3'd4, 16'd3, "R4 counts only external ticks");
        rd(3'd6, 16'h1010, "R6 disabled modes set no flag");
        chk(pulses, 2, "R9 no pulse with compare off");

        idle(3);
        finish_run();
    end
endmodule